// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative cache of page translations. A lookup presents a virtual address. The upper bits form the virtual page number, and that number is compared against every stored entry at once. When an entry matches, the block answers one clock later with a hit and a physical address. The physical address is the stored frame number followed by the untranslated page offset. When no entry matches, the block raises miss instead, and the address bus reads zero.

Each entry is tagged with a 12-bit address-space identifier and a global flag. An entry takes part in a lookup only when its tag equals the current identifier or its global flag is set. A context switch is therefore a single register write and needs no flush. Software or a walker resolves misses elsewhere and writes the result through the fill port.

Two flush commands are provided. The first clears every entry that is not global. The second clears only the entries whose virtual page equals a supplied address. When every slot is taken, the slot to replace is chosen in first-in-first-out order.

Top module: `ctx_xlate_buf`

## Requirements
- R1: After reset every entry is invalid, so the first lookup misses, and lkHit and lkMiss are both low while reset is held.
- R2: A lookup presented with lkValid high at a rising edge is answered after that same edge. On a hit, lkHit is high and lkPaddr equals the stored frame number in bits PA_W-1..PAGE_BITS, with lookup address bits PAGE_BITS-1..0 copied unchanged.
- R3: When no usable entry matches, lkMiss is high and lkPaddr is zero. lkHit and lkMiss are never high together, and both are low in a cycle that follows no lookup.
- R4: An entry is usable only when its stored identifier equals the current identifier or its global flag is set.
- R5: A write of the current identifier changes no entry. A lookup sampled at the same edge as the write still uses the old identifier, and lookups from the next edge on use the new one.
- R6: flushAll invalidates every non-global entry and leaves global entries intact.
- R7: flushOne invalidates every valid entry, global or not and whatever its identifier, whose page equals the page of flushVaddr. All other entries are left unchanged.
- R8: A fill that matches no existing entry is written to the lowest-numbered invalid slot, and the replacement pointer does not move.
- R9: When every slot is valid, a fill replaces the slot under the replacement pointer. The pointer starts at slot 0 after reset and then advances by one, wrapping modulo ENTRIES.
- R10: A fill whose page and current identifier equal those of a valid entry overwrites that entry in place, and no other entry is lost.
- R11: A fill presented in the same cycle as either flush command is discarded.
- R12: Entries are stored with the identifier that is current when their fill is accepted, and that identifier is CTX_W bits wide (12 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | VA_W | Virtual address to translate |
| lkHit | output | 1 | Lookup found a usable entry |
| lkMiss | output | 1 | Lookup found no usable entry |
| lkPaddr | output | PA_W | Translated address, zero on a miss |
| fillValid | input | 1 | Write a resolved translation |
| fillVpn | input | VA_W-PAGE_BITS | Virtual page number of the fill |
| fillPfn | input | PA_W-PAGE_BITS | Frame number of the fill |
| fillGlobal | input | 1 | Mark the filled entry global |
| ctxWrEn | input | 1 | Load the current identifier |
| ctxWrData | input | CTX_W | New current identifier |
| flushAll | input | 1 | Invalidate all non-global entries |
| flushOne | input | 1 | Invalidate entries matching flushVaddr |
| flushVaddr | input | VA_W | Address selecting the page to flush |

## Verification
The hardest state to reach from the ports is a full buffer whose replacement pointer sits somewhere other than slot 0, with gaps later reopened by flushes. The stimulus gets there in several steps. It fills the buffer, forces several evictions, and then flushes all entries except one global entry. Further fills must then land in the freed slots while the pointer stays put, and the next eviction must hit the slot the pointer had reached before the flush. Duplicate fills, same-edge identifier writes and fills that collide with a flush are driven at chosen edges, and each is checked by lookups made straight afterwards.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic doFill;
    logic doFlushAll;
    logic doFlushOne;
  } xbStrobe_t;
endpackage

// File: rtl/xb_ctrl.sv
module xb_ctrl
  import xbuf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CTX_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flushAll,
  input  logic               flushOne,
  input  logic               ctxWrEn,
  input  logic [CTX_W-1:0]   ctxWrData,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] dupVec,
  output xbStrobe_t          strobe,
  output logic [IDX_W-1:0]   fillIdx,
  output logic [CTX_W-1:0]   ctxCur
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             anyDup, anyFree, useFifo;
  logic [IDX_W-1:0] dupIdx, freeIdx, fifoPtr;

  // a flush in the same cycle discards the fill (R11)
  always_comb begin
    strobe.doFlushAll = flushAll;
    strobe.doFlushOne = flushOne;
    strobe.doFill     = fillValid && !flushAll && !flushOne;
  end

  // lowest-numbered duplicate and lowest-numbered free slot
  always_comb begin
    anyDup  = 1'b0;
    anyFree = 1'b0;
    dupIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dupVec[i]) begin
        anyDup = 1'b1;
        dupIdx = IDX_W'(i);
      end
      if (!validVec[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    useFifo = !anyDup && !anyFree;
    if (anyDup)       fillIdx = dupIdx;
    else if (anyFree) fillIdx = freeIdx;
    else              fillIdx = fifoPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoPtr <= '0;
    end else if (strobe.doFill && useFifo) begin
      fifoPtr <= (fifoPtr == LAST_IDX) ? '0 : fifoPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ctxCur <= '0;
    else if (ctxWrEn) ctxCur <= ctxWrData;
  end
endmodule

// File: rtl/xb_store.sv
module xb_store
  import xbuf_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int CTX_W     = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  xbStrobe_t          strobe,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PFN_W-1:0]   fillPfn,
  input  logic               fillGlobal,
  input  logic [CTX_W-1:0]   ctxCur,
  input  logic               lkValid,
  input  logic [VA_W-1:0]    lkVaddr,
  input  logic [VA_W-1:0]    flushVaddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] dupVec,
  output logic               lkHit,
  output logic               lkMiss,
  output logic [PA_W-1:0]    lkPaddr
);
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PFN_W-1:0]   entPfn [ENTRIES];
  logic [CTX_W-1:0]   entCtx [ENTRIES];
  logic [ENTRIES-1:0] entGlb;
  logic [ENTRIES-1:0] lkMatch;

  logic [VPN_W-1:0] lkVpn, flushVpn;
  assign lkVpn    = lkVaddr[VA_W-1:PAGE_BITS];
  assign flushVpn = flushVaddr[VA_W-1:PAGE_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    logic clrThis, wrThis;
    assign clrThis = (strobe.doFlushAll && !entGlb[g]) ||
                     (strobe.doFlushOne && entVpn[g] == flushVpn);
    assign wrThis  = strobe.doFill && fillIdx == IDX_W'(g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
        entGlb[g]   <= 1'b0;
        entVpn[g]   <= '0;
        entPfn[g]   <= '0;
        entCtx[g]   <= '0;
      end else if (clrThis) begin
        validVec[g] <= 1'b0;
      end else if (wrThis) begin
        validVec[g] <= 1'b1;
        entGlb[g]   <= fillGlobal;
        entVpn[g]   <= fillVpn;
        entPfn[g]   <= fillPfn;
        entCtx[g]   <= ctxCur;
      end
    end

    assign lkMatch[g] = validVec[g] && entVpn[g] == lkVpn &&
                        (entGlb[g] || entCtx[g] == ctxCur);
    assign dupVec[g]  = validVec[g] && entVpn[g] == fillVpn &&
                        entCtx[g] == ctxCur;
  end

  logic             anyMatch;
  logic [PFN_W-1:0] selPfn;
  always_comb begin
    anyMatch = 1'b0;
    selPfn   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        anyMatch = 1'b1;
        selPfn   = entPfn[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHit   <= 1'b0;
      lkMiss  <= 1'b0;
      lkPaddr <= '0;
    end else begin
      lkHit   <= lkValid && anyMatch;
      lkMiss  <= lkValid && !anyMatch;
      lkPaddr <= (lkValid && anyMatch) ? {selPfn, lkVaddr[PAGE_BITS-1:0]} : '0;
    end
  end
endmodule

// File: rtl/ctx_xlate_buf.sv
module ctx_xlate_buf
  import xbuf_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int CTX_W     = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lkValid,
  input  logic [VA_W-1:0]           lkVaddr,
  output logic                      lkHit,
  output logic                      lkMiss,
  output logic [PA_W-1:0]           lkPaddr,
  input  logic                      fillValid,
  input  logic [VA_W-PAGE_BITS-1:0] fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] fillPfn,
  input  logic                      fillGlobal,
  input  logic                      ctxWrEn,
  input  logic [CTX_W-1:0]          ctxWrData,
  input  logic                      flushAll,
  input  logic                      flushOne,
  input  logic [VA_W-1:0]           flushVaddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xbStrobe_t          strobe;
  logic [IDX_W-1:0]   fillIdx;
  logic [CTX_W-1:0]   ctxCur;
  logic [ENTRIES-1:0] validVec, dupVec;

  xb_ctrl #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) ctrlI (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flushAll(flushAll),
    .flushOne(flushOne), .ctxWrEn(ctxWrEn), .ctxWrData(ctxWrData),
    .validVec(validVec), .dupVec(dupVec), .strobe(strobe),
    .fillIdx(fillIdx), .ctxCur(ctxCur)
  );

  xb_store #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
             .PAGE_BITS(PAGE_BITS), .CTX_W(CTX_W)) storeI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillIdx(fillIdx),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillGlobal(fillGlobal),
    .ctxCur(ctxCur), .lkValid(lkValid), .lkVaddr(lkVaddr),
    .flushVaddr(flushVaddr), .validVec(validVec), .dupVec(dupVec),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPaddr(lkPaddr)
  );
endmodule

// File: rtl/xb_chk.sv
module xb_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVaddr,
  input logic            lkHit,
  input logic            lkMiss,
  input logic [PA_W-1:0] lkPaddr
);
  // R3
  excl_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkMiss));

  // R2
  answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (lkHit || lkMiss));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!lkHit && !lkMiss));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> lkPaddr == '0);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (lkMiss ||
                 lkPaddr[PAGE_BITS-1:0] == $past(lkVaddr[PAGE_BITS-1:0])));
endmodule

bind ctx_xlate_buf xb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) chkI (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr),
  .lkHit(lkHit), .lkMiss(lkMiss), .lkPaddr(lkPaddr)
);

// File: tb/ctx_xlate_buf_test.sv
module ctx_xlate_buf_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkHit, lkMiss;
  logic [31:0] lkPaddr;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPfn = '0;
  logic        fillGlobal = 1'b0;
  logic        ctxWrEn = 1'b0;
  logic [11:0] ctxWrData = '0;
  logic        flushAll = 1'b0;
  logic        flushOne = 1'b0;
  logic [31:0] flushVaddr = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctx_xlate_buf #(.ENTRIES(4)) uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPaddr(lkPaddr),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillGlobal(fillGlobal), .ctxWrEn(ctxWrEn), .ctxWrData(ctxWrData),
    .flushAll(flushAll), .flushOne(flushOne), .flushVaddr(flushVaddr)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        hit;
    logic [31:0] pa;
  } lkVec_t;

  localparam lkVec_t VEC [6] = '{
    '{va: 32'h0001_0123, hit: 1'b1, pa: 32'h000A_0123},
    '{va: 32'h0002_0FFF, hit: 1'b1, pa: 32'h000B_0FFF},
    '{va: 32'h0003_0001, hit: 1'b1, pa: 32'h000C_0001},
    '{va: 32'h0004_0000, hit: 1'b0, pa: 32'h0000_0000},
    '{va: 32'h0002_0000, hit: 1'b1, pa: 32'h000B_0000},
    '{va: 32'h0001_0FFE, hit: 1'b1, pa: 32'h000A_0FFE}
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic look(input logic [31:0] va, input logic expHit,
                      input logic [31:0] expPa, input string req);
    lkValid = 1'b1;
    lkVaddr = va;
    @(negedge clk);
    lkValid = 1'b0;
    check(lkHit === expHit && lkMiss === !expHit && lkPaddr === expPa,
          req, $sformatf("lookup va=%h hit=%b", va, lkHit), lkPaddr, expPa);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic glb);
    fillValid = 1'b1; fillVpn = vpn; fillPfn = pfn; fillGlobal = glb;
    @(negedge clk);
    fillValid = 1'b0; fillGlobal = 1'b0;
  endtask

  task automatic setCtx(input logic [11:0] v);
    ctxWrEn = 1'b1; ctxWrData = v;
    @(negedge clk);
    ctxWrEn = 1'b0;
  endtask

  task automatic doFlushAll();
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
  endtask

  task automatic doFlushOne(input logic [31:0] va);
    flushOne = 1'b1; flushVaddr = va;
    @(negedge clk);
    flushOne = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs while reset is held
    check(lkHit === 1'b0 && lkMiss === 1'b0, "R1", "outputs in reset",
          {30'b0, lkHit, lkMiss}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    look(32'h0001_0000, 1'b0, 32'h0, "R1");
    // R3: no lookup, no answer
    @(negedge clk);
    check(lkHit === 1'b0 && lkMiss === 1'b0, "R3", "idle outputs",
          {30'b0, lkHit, lkMiss}, 32'h0);

    // R12: fills take the current identifier 5
    setCtx(12'h005);
    fill(20'h00010, 20'h000A0, 1'b0);
    fill(20'h00020, 20'h000B0, 1'b1);
    fill(20'h00030, 20'h000C0, 1'b0);

    // R2 R3: vector table walk
    for (int i = 0; i < 6; i++) begin
      look(VEC[i].va, VEC[i].hit, VEC[i].pa, VEC[i].hit ? "R2" : "R3");
    end

    // R5: same-edge identifier write still uses the old identifier
    ctxWrEn = 1'b1; ctxWrData = 12'h007;
    lkValid = 1'b1; lkVaddr = 32'h0001_0123;
    @(negedge clk);
    ctxWrEn = 1'b0; lkValid = 1'b0;
    check(lkHit === 1'b1 && lkPaddr === 32'h000A_0123, "R5",
          "same-edge ctx write", lkPaddr, 32'h000A_0123);
    // R4: tagged entry unusable, global entry usable
    look(32'h0001_0123, 1'b0, 32'h0, "R4");
    look(32'h0002_0ABC, 1'b1, 32'h000B_0ABC, "R4");
    // R5: entries unchanged by the identifier switch
    setCtx(12'h005);
    look(32'h0001_0123, 1'b1, 32'h000A_0123, "R5");

    // R10: duplicate overwrite in place
    fill(20'h00010, 20'h000A5, 1'b0);
    look(32'h0001_0000, 1'b1, 32'h000A_5000, "R10");
    fill(20'h00040, 20'h000D0, 1'b0);
    look(32'h0003_0000, 1'b1, 32'h000C_0000, "R10");
    look(32'h0004_0000, 1'b1, 32'h000D_0000, "R8");

    // R9: full, pointer evicts slot 0 then slot 1
    fill(20'h00050, 20'h000E0, 1'b0);
    look(32'h0001_0000, 1'b0, 32'h0, "R9");
    look(32'h0005_0000, 1'b1, 32'h000E_0000, "R9");
    look(32'h0002_0000, 1'b1, 32'h000B_0000, "R9");
    fill(20'h00060, 20'h000F0, 1'b0);
    look(32'h0002_0000, 1'b0, 32'h0, "R9");
    look(32'h0003_0000, 1'b1, 32'h000C_0000, "R9");
    fill(20'h00070, 20'h00070, 1'b1);
    look(32'h0003_0000, 1'b0, 32'h0, "R9");

    // R7: one page flushed, others kept
    doFlushOne(32'h0004_0ABC);
    look(32'h0004_0000, 1'b0, 32'h0, "R7");
    look(32'h0005_0000, 1'b1, 32'h000E_0000, "R7");

    // R6: non-global cleared, global kept
    doFlushAll();
    look(32'h0005_0000, 1'b0, 32'h0, "R6");
    look(32'h0007_0000, 1'b1, 32'h0007_0000, "R6");

    // R8: free slots 0,1,3 filled; pointer stays at slot 3
    fill(20'h00080, 20'h00081, 1'b0);
    fill(20'h00090, 20'h00091, 1'b0);
    fill(20'h000A0, 20'h000A1, 1'b0);
    look(32'h0007_0000, 1'b1, 32'h0007_0000, "R8");
    fill(20'h000B0, 20'h000B1, 1'b0);
    look(32'h000A_0000, 1'b0, 32'h0, "R8");
    look(32'h0008_0000, 1'b1, 32'h0008_1000, "R8");
    look(32'h0009_0000, 1'b1, 32'h0009_1000, "R8");
    look(32'h000B_0000, 1'b1, 32'h000B_1000, "R9");

    // R7: flush by page also removes a global entry
    doFlushOne(32'h0007_0000);
    look(32'h0007_0000, 1'b0, 32'h0, "R7");

    // R11: fill colliding with a flush is dropped
    fillValid = 1'b1; fillVpn = 20'h000C0; fillPfn = 20'h000C1;
    flushAll = 1'b1;
    @(negedge clk);
    fillValid = 1'b0; flushAll = 1'b0;
    look(32'h000C_0000, 1'b0, 32'h0, "R11");
    fill(20'h000D0, 20'h000D1, 1'b1);
    fillValid = 1'b1; fillVpn = 20'h000E0; fillPfn = 20'h000E1;
    flushOne = 1'b1; flushVaddr = 32'h0000_0000;
    @(negedge clk);
    fillValid = 1'b0; flushOne = 1'b0;
    look(32'h000E_0000, 1'b0, 32'h0, "R11");
    look(32'h000D_0000, 1'b1, 32'h000D_1000, "R11");

    // R1: reset clears global entries too
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    look(32'h000D_0000, 1'b0, 32'h0, "R1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule